// File: doc/BRIEF.md
# Scatter-gather DMA window translator

This block sits on an I/O bridge port and turns a 32-bit bus DMA address into a physical memory address. Software programs four windows. Each window has a base register, a mask register and a translated-base register. An incoming address is compared against each enabled window at 1 MB granularity. A window that matches maps the address in one of two ways. In direct mode it adds the window offset to the translated base. In scatter-gather mode it looks up a page table entry in memory, located through the translated base.

Recently used page table entries sit in a small cache of two lines with four entries each. A miss reads one aligned group of four entries through a simple memory read port. Software can flush the cache with a write to one of two invalidate registers. One flushes everything. The other flushes only the lines whose bus address bits 31:16 match a tag.

The translation request, the translation response and the memory read request are valid/ready channels. A source holds valid and its payload unchanged until the cycle in which ready is high, and the transfer takes place in that cycle. The block takes one request at a time: req_ready is high only while no translation is in progress. The memory response is a one-cycle pulse that has no ready signal, and it must only arrive after the memory request has been accepted.

Top module: `sg_dma_xlate`

## Requirements
- R1: Bit 0 of a window base register enables the window, and writing zero disables it. When no enabled window matches, the response carries rsp_nohit=1, rsp_fault=0 and rsp_paddr=0.
- R2: A window matches when (addr[31:20] XOR base[31:20]) AND NOT mask[31:20] is zero. When several windows match, the lowest-numbered one is used.
- R3: In a direct window (base bit 1 = 0, windows 0 to 2), rsp_paddr = tbase + (addr AND {mask[31:20], 20'hFFFFF}).
- R4: A window with base bit 1 = 1 uses scatter-gather, and window 3 always does, whatever its bit 1 says. The entry address is tbase + (offset >> 13) * 8. The result is rsp_paddr = low 32 bits of ((entry >> 1) << 13) OR addr[12:0].
- R5: An entry whose bit 0 is 0 is not valid. The response then carries rsp_fault=1, rsp_nohit=0 and rsp_paddr=0.
- R6: A cache miss issues one memory read at the entry address rounded down to a multiple of 32. The returned data carries entry k of the group in bits [32k+31:32k]. Further requests in the same 32 KB bus region are then served with no memory read.
- R7: The cache holds two lines and replaces them round-robin. After regions A, B and C are filled, A needs a fetch again and C still hits.
- R8: Any write to register index 12 (invalidate-all) flushes every line, whatever the data.
- R9: A write to register index 13 (invalidate-one) flushes the lines whose bus address bits 31:16 equal wdata[19:4]. Other lines are kept.
- R10: An invalidate that covers a fetch in flight lets that request finish with the fetched entry, but the line is not kept.
- R11: A request is accepted only while req_ready is high. rsp_valid and its payload stay unchanged until rsp_ready. mem_req_valid and mem_req_addr stay unchanged until mem_req_ready.
- R12: Reading index w, 4+w or 8+w returns the base, mask or tbase of window w. A base reads back only bits 31:20 and 1:0, a mask only bits 31:20, and every other bit reads as zero. All registers are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 32 | Bus DMA address |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Result consumer ready |
| rsp_paddr | output | 32 | Physical address |
| rsp_nohit | output | 1 | No window matched |
| rsp_fault | output | 1 | Page table entry not valid |
| mem_req_valid | output | 1 | Entry group read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Group byte address |
| mem_rsp_valid | input | 1 | Read data pulse |
| mem_rsp_data | input | 128 | Four page table entries |

## Verification
The bench builds the block with its default parameters: four windows, two cache lines of four entries, 8 KB pages and a 1 MB window grain. With two lines, a third distinct 32 KB region is enough to force an eviction, so the round-robin order can be seen in the count of memory reads. With four windows, two overlapping direct windows can be set up, alongside one scatter-gather window with its mode bit set and the last window with its mode bit clear. Memory latency of up to eight cycles leaves room to land an invalidate while a fetch is in flight, and toggling the ready inputs exercises back-pressure on every channel.

// File: rtl/sgx_pkg.sv
package sgx_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_DECIDE, ST_MREQ, ST_MWAIT, ST_RESP} sgx_state_e;
  localparam int PTE_BYTES = 8;
  localparam int TBI_SHIFT = 12;
  localparam int TBI_LSB   = 16;
endpackage

// File: rtl/sgx_win_decode.sv
module sgx_win_decode #(
  parameter int NW   = 4,
  parameter int AW   = 32,
  parameter int MLSB = 20
) (
  input  logic [AW-1:0]                addr,
  input  logic [NW-1:0]                win_en,
  input  logic [NW-1:0]                win_sg,
  input  logic [NW-1:0][AW-MLSB-1:0]   base_hi,
  input  logic [NW-1:0][AW-MLSB-1:0]   mask_hi,
  input  logic [NW-1:0][AW-1:0]        tbase,
  output logic                         hit,
  output logic                         sg,
  output logic [AW-1:0]                offset,
  output logic [AW-1:0]                tsel
);
  logic [NW-1:0]         match;
  logic [NW-1:0]         sg_w;
  logic [NW-1:0][AW-1:0] span;

  for (genvar w = 0; w < NW; w++) begin : g_win
    assign span[w]  = {mask_hi[w], {MLSB{1'b1}}};
    assign match[w] = win_en[w] &&
                      (((addr[AW-1:MLSB] ^ base_hi[w]) & ~mask_hi[w]) == '0);
    if (w == NW - 1) begin : g_last
      assign sg_w[w] = 1'b1;
    end else begin : g_other
      assign sg_w[w] = win_sg[w];
    end
  end

  always_comb begin
    hit    = 1'b0;
    sg     = 1'b0;
    offset = '0;
    tsel   = '0;
    for (int w = NW - 1; w >= 0; w--) begin
      if (match[w]) begin
        hit    = 1'b1;
        sg     = sg_w[w];
        offset = addr & span[w];
        tsel   = tbase[w];
      end
    end
  end
endmodule

// File: rtl/sgx_pte_cache.sv
module sgx_pte_cache #(
  parameter int PTE_W = 32,
  parameter int LINES = 2,
  parameter int GRP   = 4,
  parameter int TAG_W = 17,
  parameter int INV_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [TAG_W-1:0]       lk_tag,
  input  logic [$clog2(GRP)-1:0] lk_idx,
  output logic                   lk_hit,
  output logic [PTE_W-1:0]       lk_pte,
  input  logic                   fill_start,
  input  logic                   fill_en,
  input  logic [GRP*PTE_W-1:0]   fill_data,
  input  logic                   inv_all,
  input  logic                   inv_one,
  input  logic [INV_W-1:0]       inv_tag
);
  localparam int LW = (LINES > 1) ? $clog2(LINES) : 1;

  logic [LINES-1:0]                v_q;
  logic [LINES-1:0][TAG_W-1:0]     tag_q;
  logic [LINES-1:0][GRP*PTE_W-1:0] data_q;
  logic [LW-1:0]                   rr_q;
  logic                            stale_q;
  logic [LINES-1:0]                kill;
  logic                            kill_pend;

  for (genvar l = 0; l < LINES; l++) begin : g_kill
    assign kill[l] = inv_all || (inv_one && tag_q[l][TAG_W-1 -: INV_W] == inv_tag);
  end
  assign kill_pend = inv_all || (inv_one && lk_tag[TAG_W-1 -: INV_W] == inv_tag);

  always_comb begin
    lk_hit = 1'b0;
    lk_pte = '0;
    for (int l = 0; l < LINES; l++) begin
      if (v_q[l] && tag_q[l] == lk_tag) begin
        lk_hit = 1'b1;
        lk_pte = data_q[l][lk_idx*PTE_W +: PTE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q     <= '0;
      tag_q   <= '0;
      data_q  <= '0;
      rr_q    <= '0;
      stale_q <= 1'b0;
    end else begin
      v_q <= v_q & ~kill;
      if (fill_start)     stale_q <= kill_pend;
      else if (kill_pend) stale_q <= 1'b1;
      if (fill_en && !stale_q && !kill_pend) begin
        v_q[rr_q]    <= 1'b1;
        tag_q[rr_q]  <= lk_tag;
        data_q[rr_q] <= fill_data;
        rr_q         <= (rr_q == LW'(LINES - 1)) ? '0 : rr_q + 1'b1;
      end
    end
  end

  a_r8_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (v_q == '0));

  a_r10_no_stale_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && stale_q && !lk_hit) |=> !lk_hit);
endmodule

// File: rtl/sg_dma_xlate.sv
module sg_dma_xlate
  import sgx_pkg::*;
#(
  parameter int NW      = 4,
  parameter int AW      = 32,
  parameter int MLSB    = 20,
  parameter int PAGE_SH = 13,
  parameter int PTE_W   = 32,
  parameter int LINES   = 2,
  parameter int GRP     = 4,
  localparam int RA_W   = $clog2(3*NW + 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [RA_W-1:0]      reg_addr,
  input  logic [AW-1:0]        reg_wdata,
  output logic [AW-1:0]        reg_rdata,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [AW-1:0]        req_addr,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [AW-1:0]        rsp_paddr,
  output logic                 rsp_nohit,
  output logic                 rsp_fault,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [AW-1:0]        mem_req_addr,
  input  logic                 mem_rsp_valid,
  input  logic [GRP*PTE_W-1:0] mem_rsp_data
);
  localparam int HW        = AW - MLSB;
  localparam int GIW       = $clog2(GRP);
  localparam int TAG_W     = AW - PAGE_SH - GIW;
  localparam int INV_W     = AW - TBI_LSB;
  localparam int PTE_SH    = $clog2(PTE_BYTES);
  localparam int GRP_BYTES = GRP * PTE_BYTES;
  localparam int IDX_ALL   = 3 * NW;
  localparam int IDX_ONE   = 3 * NW + 1;

  logic [NW-1:0]         win_en_q, win_sg_q;
  logic [NW-1:0][HW-1:0] base_hi_q, mask_hi_q;
  logic [NW-1:0][AW-1:0] tbase_q;

  sgx_state_e     state_q;
  logic [AW-1:0]  addr_q, mreq_addr_q, paddr_q;
  logic           nohit_q, fault_q;

  logic           d_hit, d_sg;
  logic [AW-1:0]  d_off, d_tsel, pte_addr, grp_addr;
  logic           c_hit;
  logic [PTE_W-1:0] c_pte, m_pte;
  logic           fill_start, fill_en, inv_all, inv_one;
  logic [INV_W-1:0] inv_tag;

  // register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_en_q  <= '0;
      win_sg_q  <= '0;
      base_hi_q <= '0;
      mask_hi_q <= '0;
      tbase_q   <= '0;
    end else if (reg_we) begin
      for (int w = 0; w < NW; w++) begin
        if (reg_addr == RA_W'(w)) begin
          base_hi_q[w] <= reg_wdata[AW-1:MLSB];
          win_en_q[w]  <= reg_wdata[0];
          win_sg_q[w]  <= reg_wdata[1];
        end
        if (reg_addr == RA_W'(NW + w))   mask_hi_q[w] <= reg_wdata[AW-1:MLSB];
        if (reg_addr == RA_W'(2*NW + w)) tbase_q[w]   <= reg_wdata;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int w = 0; w < NW; w++) begin
      if (reg_addr == RA_W'(w))
        reg_rdata = {base_hi_q[w], {(MLSB-2){1'b0}}, win_sg_q[w], win_en_q[w]};
      if (reg_addr == RA_W'(NW + w))   reg_rdata = {mask_hi_q[w], {MLSB{1'b0}}};
      if (reg_addr == RA_W'(2*NW + w)) reg_rdata = tbase_q[w];
    end
  end

  assign inv_all = reg_we && reg_addr == RA_W'(IDX_ALL);
  assign inv_one = reg_we && reg_addr == RA_W'(IDX_ONE);
  assign inv_tag = reg_wdata[TBI_LSB-TBI_SHIFT +: INV_W];

  sgx_win_decode #(.NW(NW), .AW(AW), .MLSB(MLSB)) u_dec (
    .addr(addr_q), .win_en(win_en_q), .win_sg(win_sg_q),
    .base_hi(base_hi_q), .mask_hi(mask_hi_q), .tbase(tbase_q),
    .hit(d_hit), .sg(d_sg), .offset(d_off), .tsel(d_tsel)
  );

  assign pte_addr = d_tsel + (AW'(d_off >> PAGE_SH) << PTE_SH);
  assign grp_addr = pte_addr & ~AW'(GRP_BYTES - 1);
  assign m_pte    = mem_rsp_data[addr_q[PAGE_SH +: GIW]*PTE_W +: PTE_W];

  assign fill_start = (state_q == ST_DECIDE) && d_hit && d_sg && !c_hit;
  assign fill_en    = (state_q == ST_MWAIT) && mem_rsp_valid;

  sgx_pte_cache #(.PTE_W(PTE_W), .LINES(LINES), .GRP(GRP), .TAG_W(TAG_W),
                  .INV_W(INV_W)) u_cache (
    .clk(clk), .rst_n(rst_n),
    .lk_tag(addr_q[AW-1 -: TAG_W]), .lk_idx(addr_q[PAGE_SH +: GIW]),
    .lk_hit(c_hit), .lk_pte(c_pte),
    .fill_start(fill_start), .fill_en(fill_en), .fill_data(mem_rsp_data),
    .inv_all(inv_all), .inv_one(inv_one), .inv_tag(inv_tag)
  );

  // translation sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      mreq_addr_q <= '0;
      paddr_q     <= '0;
      nohit_q     <= 1'b0;
      fault_q     <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          state_q <= ST_DECIDE;
        end
        ST_DECIDE: begin
          nohit_q <= 1'b0;
          fault_q <= 1'b0;
          paddr_q <= '0;
          if (!d_hit) begin
            nohit_q <= 1'b1;
            state_q <= ST_RESP;
          end else if (!d_sg) begin
            paddr_q <= d_tsel + d_off;
            state_q <= ST_RESP;
          end else if (c_hit) begin
            fault_q <= !c_pte[0];
            if (c_pte[0]) paddr_q <= AW'({c_pte >> 1, addr_q[PAGE_SH-1:0]});
            state_q <= ST_RESP;
          end else begin
            mreq_addr_q <= grp_addr;
            state_q     <= ST_MREQ;
          end
        end
        ST_MREQ: if (mem_req_ready) state_q <= ST_MWAIT;
        ST_MWAIT: if (mem_rsp_valid) begin
          fault_q <= !m_pte[0];
          if (m_pte[0]) paddr_q <= AW'({m_pte >> 1, addr_q[PAGE_SH-1:0]});
          state_q <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign rsp_valid     = (state_q == ST_RESP);
  assign rsp_paddr     = paddr_q;
  assign rsp_nohit     = nohit_q;
  assign rsp_fault     = fault_q;
  assign mem_req_valid = (state_q == ST_MREQ);
  assign mem_req_addr  = mreq_addr_q;

  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) &&
                                   $stable(rsp_nohit) && $stable(rsp_fault)));

  a_r11_mreq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r5_flag_excl: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!(rsp_nohit && rsp_fault) &&
                   (!(rsp_nohit || rsp_fault) || rsp_paddr == '0)));

  a_r6_fetch_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !c_hit);
endmodule

// File: tb/tb_sg_dma_xlate.sv
module tb_sg_dma_xlate;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic req_valid = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic rsp_valid, rsp_ready = 1'b0, rsp_nohit, rsp_fault;
  logic [31:0] rsp_paddr;
  logic mem_req_valid, mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [127:0] mem_rsp_data = '0;

  int checks = 0, errors = 0, fetches = 0, mem_lat = 2, f0;
  logic [31:0] exp_grp = '0;
  logic [31:0] m_base[4], m_mask[4], m_tbase[4];
  logic [33:0] sb_q[$];

  always #5 clk = ~clk;

  sg_dma_xlate dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pte_at(input logic [31:0] a);
    logic [31:0] i;
    i = a >> 3;
    pte_at = {12'b0, 19'(i * 37 + 11), ((i % 7) != 3)};
  endfunction

  task automatic model(input logic [31:0] a, output logic [33:0] r, output logic [31:0] grp);
    logic [31:0] span, off, pta, pte;
    bit found = 0;
    r = {2'b10, 32'h0};
    grp = '0;
    for (int w = 0; w < 4; w++) begin
      if (!found && m_base[w][0] &&
          (((a ^ m_base[w]) & ~m_mask[w] & 32'hFFF0_0000) == 0)) begin
        found = 1;
        span = m_mask[w] | 32'h000F_FFFF;
        off = a & span;
        if (!m_base[w][1] && w != 3) r = {2'b00, m_tbase[w] + off};
        else begin
          pta = m_tbase[w] + ((off >> 13) << 3);
          pte = pte_at(pta);
          grp = pta & ~32'h1F;
          if (!pte[0]) r = {2'b01, 32'h0};
          else r = {2'b00, ((pte >> 1) << 13) | {19'b0, a[12:0]}};
        end
      end
    end
  endtask

  task automatic reg_write(input int idx, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = 4'(idx); reg_wdata = d;
    if (idx < 4) m_base[idx] = d & 32'hFFF0_0003;
    else if (idx < 8) m_mask[idx-4] = d & 32'hFFF0_0000;
    else if (idx < 12) m_tbase[idx-8] = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic reg_chk(input int idx, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = 4'(idx);
    #1 chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic send(input logic [31:0] a);
    logic [33:0] r;
    logic [31:0] g;
    model(a, r, g);
    exp_grp = g;
    sb_q.push_back(r);
    @(negedge clk);
    req_valid = 1; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    wait (sb_q.size() == 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic fetch_chk(input int delta, input string tag);
    chk(fetches == f0 + delta, tag, 64'(fetches - f0), 64'(delta));
    f0 = fetches;
  endtask

  // memory responder
  initial begin
    int mc = 0;
    logic [31:0] a;
    forever begin
      @(negedge clk);
      mc++;
      mem_req_ready = (mc % 4) != 2;
      if (mem_req_valid && mem_req_ready) begin
        fetches++;
        a = mem_req_addr;
        chk(a == exp_grp, "R6 group address", a, exp_grp);
        repeat (mem_lat) @(negedge clk);
        for (int k = 0; k < 4; k++) mem_rsp_data[k*32 +: 32] = pte_at(a + 32'(8*k));
        mem_rsp_valid = 1;
        @(negedge clk);
        mem_rsp_valid = 0;
      end
    end
  end

  // response monitor / scoreboard
  initial begin
    int cyc = 0;
    bit held = 0;
    logic [33:0] hv, e;
    forever begin
      @(negedge clk);
      cyc++;
      rsp_ready = (cyc % 3) != 1;
      if (held) chk(rsp_valid && {rsp_nohit, rsp_fault, rsp_paddr} == hv,
                    "R11 response held", {rsp_valid, rsp_nohit, rsp_fault, rsp_paddr}, {1'b1, hv});
      held = rsp_valid && !rsp_ready;
      hv = {rsp_nohit, rsp_fault, rsp_paddr};
      if (rsp_valid && rsp_ready) begin
        if (sb_q.size() == 0) chk(0, "R11 unexpected response", hv, 0);
        else begin
          e = sb_q.pop_front();
          chk(hv == e, "R1-R5 translation result", hv, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int w = 0; w < 4; w++) begin m_base[w] = 0; m_mask[w] = 0; m_tbase[w] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid, "R12 reset state",
        {req_ready, rsp_valid, mem_req_valid}, 3'b100);
    reg_chk(0, 0, "R12 reset base");
    reg_chk(9, 0, "R12 reset tbase");
    send(32'h1000_0000);                         // R1 all windows disabled

    reg_write(0, 32'h1000_FFF1);
    reg_write(4, 32'h00FF_FFFF);
    reg_write(8, 32'h2000_0000);
    reg_write(1, 32'h1000_0001);
    reg_write(5, 32'h0FF0_0000);
    reg_write(9, 32'h6000_0000);
    reg_write(2, 32'h8000_0003);
    reg_write(6, 32'h0030_0000);
    reg_write(10, 32'h0010_0000);
    reg_write(3, 32'hC000_0001);
    reg_write(7, 32'h0000_0000);
    reg_write(11, 32'h0020_0000);
    reg_chk(0, 32'h1000_0001, "R12 base readback");
    reg_chk(4, 32'h00F0_0000, "R12 mask readback");
    reg_chk(10, 32'h0010_0000, "R12 tbase readback");

    send(32'h1080_0004);                         // R2 R3 window 0 wins
    send(32'h10FF_FFFF);                         // R3 last byte of window 0
    send(32'h1100_0000);                         // R2 falls to window 1
    send(32'h1FFF_FFFC);                         // R3 last word of window 1
    send(32'h2000_0000);                         // R1 no hit

    f0 = fetches;
    send(32'h8000_0123);  fetch_chk(1, "R6 first miss fetches");
    send(32'h8000_6010);  fetch_chk(0, "R6 same line hits");
    send(32'h8000_C000);  fetch_chk(1, "R5 fault entry fetch");
    send(32'h8001_0000);  fetch_chk(1, "R7 third region fetch");
    send(32'h8000_2000);  fetch_chk(1, "R7 evicted region refetch");
    send(32'h8001_0004);  fetch_chk(0, "R7 newer line kept");
    send(32'hC00F_E000);  fetch_chk(1, "R4 window 3 scatter-gather");

    reg_write(12, 32'h1234_5678);
    send(32'h8000_0000);  fetch_chk(1, "R8 flush all");
    send(32'h8000_0008);  fetch_chk(0, "R8 refilled line hits");
    send(32'h8001_2000);  fetch_chk(1, "R9 second region fill");
    reg_write(13, 32'h8001 << 12 >> 12 << 4);
    send(32'h8000_4000);  fetch_chk(0, "R9 other line kept");
    send(32'h8001_2000);  fetch_chk(1, "R9 matching line flushed");

    mem_lat = 8;
    fork
      send(32'h8003_0000);
      begin wait (fetches == f0 + 1); @(negedge clk); reg_write(13, 32'h0008_0030); end
    join
    fetch_chk(1, "R10 fetch during invalidate");
    send(32'h8003_0000);  fetch_chk(1, "R10 stale fill dropped");
    fork
      send(32'h8004_0000);
      begin wait (fetches == f0 + 1); @(negedge clk); reg_write(13, 32'h0009_9990); end
    join
    fetch_chk(1, "R10 fetch with unrelated invalidate");
    send(32'h8004_0000);  fetch_chk(0, "R10 unrelated fill kept");
    mem_lat = 2;

    reg_write(0, 32'h0);
    send(32'h1080_0004);                         // R1 window 0 disabled, window 1 serves
    reg_write(1, 32'h0);
    send(32'h1080_0004);                         // R1 no hit once both disabled
    chk(sb_q.size() == 0, "R11 all responses seen", 64'(sb_q.size()), 0);
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule